// File: doc/BRIEF.md
# Paced Memory Request Generator

This block stands in for a processor core that feeds a memory controller. While it is active it raises one memory request every ten clock cycles. Each request carries a read/write flag and a byte address aligned to a 64-byte line inside a 128 MB space. Requests leave through a valid/ready pair. A request that the controller has not yet taken stays on the outputs unchanged, and the pacing interval only starts again once that request has been accepted.

The controller pushes back with two single-cycle pulses. A stall pulse sends the block into a stalled state in which it creates no new requests. A resume pulse brings it back to the active state and restarts the pacing interval. Reads and writes follow a fixed repeating pattern of two reads and then one write. Addresses come from a 32-bit shift register whose starting value is loaded from a seed input at reset, so a test can reproduce any run exactly.

Top module: `memreq_pacer`

## Requirements
- R1: While reset is high and in the cycle after it is released, req_valid is low. The block leaves reset in the active state.
- R2: With req_ready held high, the first req_valid appears after the 10th rising edge following reset release. Each later request's req_valid rises exactly 10 cycles after the start of the cycle in which the previous request was accepted.
- R3: Accepted requests follow the pattern read, read, write, repeating from reset. req_write is 1 for a write and 0 for a read.
- R4: A 32-bit register holds the address state. It is loaded from seed at reset and advances once per new request, and each step shifts left with new bit 0 = s[31]^s[21]^s[1]^s[0]. req_addr is bits 26..6 of the advanced state with bits 5..0 forced to zero.
- R5: While req_valid is high and req_ready is low, req_valid, req_write and req_addr hold steady and the pacing interval is paused. The next request appears 10 cycles after the acceptance cycle.
- R6: A stall pulse taken while no request is pending moves the block to the stalled state from the next cycle. No request is raised while it stays stalled.
- R7: A stall pulse taken while a request is pending but not accepted keeps that request valid until it is accepted. The block then enters the stalled state and raises no new request.
- R8: A resume pulse taken in the stalled state returns the block to active and clears the pacing count. The first request's req_valid rises after the 10th rising edge following the one that took the resume pulse.
- R9: A resume pulse in the active state and a stall pulse in the stalled state have no effect. In particular, pacing is not disturbed.
- R10: A seed of zero is replaced by 1, so after reset with seed 0 the first request is a read at address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed | input | 32 | Address-generator start value, loaded during reset |
| stall_i | input | 1 | Single-cycle pulse asking the block to stop |
| resume_i | input | 1 | Single-cycle pulse asking the block to restart |
| req_valid | output | 1 | A request is presented |
| req_ready | input | 1 | Controller accepts the presented request |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 27 | Line-aligned byte address |

## Verification
Several properties are checked on every cycle. A presented but unaccepted request must stay stable, every address must be line-aligned, no request may appear while stalled, a stall must take effect at once when idle and be deferred when a request is pending, and a resume must wake the block. The exact 10-cycle spacing, the read/read/write pattern, the address sequence from a given seed and the lack of effect of misplaced pulses depend on history over many cycles. Only the bench's timed scenarios and its scoreboard show those.

// File: rtl/memreq_pkg.sv
package memreq_pkg;

    localparam int STATE_W   = 32;
    localparam int ADDR_W    = 27;
    localparam int LINE_BITS = 6;
    localparam int PACE      = 10;
    localparam int MIX_LEN   = 3;

    typedef enum logic {
        ST_ACTIVE  = 1'b0,
        ST_STALLED = 1'b1
    } gen_state_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
    } mem_req_t;

    function automatic logic [STATE_W-1:0] shift_step(input logic [STATE_W-1:0] s);
        return {s[STATE_W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

endpackage

// File: rtl/pace_timer.sv
module pace_timer #(
    parameter int PACE_CYCLES = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic advance,
    output logic at_end
);
    localparam int CW = (PACE_CYCLES > 1) ? $clog2(PACE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(PACE_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    assign at_end = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (advance) begin
            cnt_q <= at_end ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mix_slot.sv
module mix_slot #(
    parameter int PERIOD = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    output logic is_write
);
    localparam int SW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [SW-1:0] LAST = SW'(PERIOD - 1);

    logic [SW-1:0] slot_q;

    assign is_write = (slot_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else if (step) begin
            slot_q <= is_write ? '0 : slot_q + 1'b1;
        end
    end
endmodule

// File: rtl/addr_lfsr.sv
module addr_lfsr
    import memreq_pkg::*;
#(
    parameter int AW = 27,
    parameter int LB = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [STATE_W-1:0] seed,
    input  logic               step,
    output logic [AW-1:0]      next_addr
);
    logic [STATE_W-1:0] st_q;
    logic [STATE_W-1:0] st_nx;
    logic [AW-1:0]      line_mask;

    assign st_nx     = shift_step(st_q);
    assign line_mask = ~(AW'((1 << LB) - 1));
    assign next_addr = st_nx[AW-1:0] & line_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= (seed == '0) ? STATE_W'(1) : seed;
        end else if (step) begin
            st_q <= st_nx;
        end
    end
endmodule

// File: rtl/memreq_pacer.sv
module memreq_pacer
    import memreq_pkg::*;
#(
    parameter int PACE_CYCLES = PACE,
    parameter int MIX_PERIOD  = MIX_LEN,
    parameter int AW          = ADDR_W,
    parameter int LB          = LINE_BITS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [STATE_W-1:0] seed,
    input  logic               stall_i,
    input  logic               resume_i,
    output logic               req_valid,
    input  logic               req_ready,
    output logic               req_write,
    output logic [AW-1:0]      req_addr
);
    gen_state_e state_q, state_d;
    logic       pending_q;
    logic       defer_q;
    logic       stalled_w;
    logic       handshake;
    logic       fire;
    logic       adv;
    logic       wake;
    logic       tick_end;
    logic       slot_wr;
    logic [AW-1:0] addr_nx;

    typedef struct packed {
        logic          wr;
        logic [AW-1:0] addr;
    } out_req_t;

    out_req_t req_q;

    assign stalled_w = (state_q == ST_STALLED);
    assign handshake = pending_q && req_ready;
    assign wake      = stalled_w && resume_i;
    assign adv       = !stalled_w && (!pending_q || handshake);
    assign fire      = !stalled_w && !defer_q && !stall_i && !pending_q && tick_end;

    pace_timer #(.PACE_CYCLES(PACE_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (wake),
        .advance (adv),
        .at_end  (tick_end)
    );

    mix_slot #(.PERIOD(MIX_PERIOD)) u_mix (
        .clk      (clk),
        .rst      (rst),
        .step     (fire),
        .is_write (slot_wr)
    );

    addr_lfsr #(.AW(AW), .LB(LB)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .seed      (seed),
        .step      (fire),
        .next_addr (addr_nx)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE: begin
                if ((stall_i && (!pending_q || handshake)) || (defer_q && handshake)) begin
                    state_d = ST_STALLED;
                end
            end
            ST_STALLED: begin
                if (resume_i) begin
                    state_d = ST_ACTIVE;
                end
            end
            default: state_d = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_ACTIVE;
            pending_q <= 1'b0;
            defer_q   <= 1'b0;
            req_q     <= '0;
        end else begin
            state_q <= state_d;
            if (fire) begin
                pending_q <= 1'b1;
                req_q.wr   <= slot_wr;
                req_q.addr <= addr_nx;
            end else if (handshake) begin
                pending_q <= 1'b0;
            end
            if (handshake) begin
                defer_q <= 1'b0;
            end else if (!stalled_w && stall_i && pending_q) begin
                defer_q <= 1'b1;
            end
        end
    end

    assign req_valid = pending_q;
    assign req_write = req_q.wr;
    assign req_addr  = req_q.addr;
endmodule

// File: rtl/memreq_pacer_chk.sv
module memreq_pacer_chk #(
    parameter int AW = 27,
    parameter int LB = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          stall_i,
    input logic          resume_i,
    input logic          req_valid,
    input logic          req_ready,
    input logic          req_write,
    input logic [AW-1:0] req_addr,
    input logic          stalled
);
    AST_HELD_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_write) && $stable(req_addr)); // R5

    AST_LINE_ALIGN: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> req_addr[LB-1:0] == '0); // R4

    AST_QUIET_STALL: assert property (@(posedge clk) disable iff (rst)
        stalled |-> !req_valid); // R6

    AST_STALL_TAKES: assert property (@(posedge clk) disable iff (rst)
        !stalled && stall_i && !req_valid |=> stalled); // R6

    AST_DRAIN_FIRST: assert property (@(posedge clk) disable iff (rst)
        !stalled && stall_i && req_valid && !req_ready |=> req_valid && !stalled); // R7

    AST_RESUME_WAKE: assert property (@(posedge clk) disable iff (rst)
        stalled && resume_i |=> !stalled && !req_valid); // R8
endmodule

bind memreq_pacer memreq_pacer_chk #(.AW(AW), .LB(LB)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .stall_i   (stall_i),
    .resume_i  (resume_i),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .stalled   (stalled_w)
);

// File: tb/memreq_pacer_test.sv
module memreq_pacer_test;
    localparam int CLK_PERIOD = 10;
    localparam int AWB = 27;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [31:0]    seed = 32'h1234_5678;
    logic           stall_i = 1'b0;
    logic           resume_i = 1'b0;
    logic           req_valid;
    logic           req_ready = 1'b1;
    logic           req_write;
    logic [AWB-1:0] req_addr;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    bit             exp_wr[$];
    logic [AWB-1:0] exp_ad[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    memreq_pacer uut (
        .clk       (clk),
        .rst       (rst),
        .seed      (seed),
        .stall_i   (stall_i),
        .resume_i  (resume_i),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // driver: expected requests from the R3 pattern and the R4 sequence
    task automatic load_expected(input logic [31:0] sd, input int n);
        logic [31:0] s;
        exp_wr.delete();
        exp_ad.delete();
        s = (sd == 0) ? 32'd1 : sd;
        for (int i = 0; i < n; i++) begin
            s = {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
            exp_wr.push_back((i % 3) == 2);
            exp_ad.push_back({s[26:6], 6'b0});
        end
    endtask

    // monitor: pops one expected item per accepted request
    always begin
        @(negedge clk);
        #1;
        if (!rst && req_valid && req_ready) begin
            if (exp_wr.size() == 0) begin
                check(0, "R3", "unexpected request", 1, 0);
            end else begin
                bit             ew;
                logic [AWB-1:0] ea;
                ew = exp_wr.pop_front();
                ea = exp_ad.pop_front();
                check(req_write == ew, "R3", "read/write order", req_write, ew);
                check(req_addr == ea, "R4", "address", req_addr, ea);
            end
        end
    end

    task automatic pulse_stall();
        stall_i = 1'b1;
        @(negedge clk);
        stall_i = 1'b0;
    endtask

    task automatic pulse_resume();
        resume_i = 1'b1;
        @(negedge clk);
        resume_i = 1'b0;
    endtask

    // cycles until req_valid is seen, starting from the current negedge
    task automatic wait_first(output int n);
        n = 0;
        while (!req_valid && n < 300) begin
            @(negedge clk);
            n++;
        end
    endtask

    // cycles from an accepted request to the next request
    task automatic wait_next(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!req_valid && n < 300);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        check(0, "R2", "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        int n;
        int seen;
        bit             hw;
        logic [AWB-1:0] ha;

        load_expected(seed, 80);
        repeat (3) @(negedge clk);
        check(req_valid == 1'b0, "R1", "valid during reset", req_valid, 0);
        rst = 1'b0;
        check(req_valid == 1'b0, "R1", "valid at reset release", req_valid, 0);

        wait_first(n);
        check(n == 10, "R2", "first request delay", n, 10);
        for (int k = 0; k < 6; k++) begin
            wait_next(n);
            check(n == 10, "R2", "request spacing", n, 10);
        end

        // R5: back-pressure holds the request
        req_ready = 1'b0;
        hw = req_write;
        ha = req_addr;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check(req_valid == 1'b1, "R5", "valid held", req_valid, 1);
            check(req_write == hw && req_addr == ha, "R5", "fields held", req_addr, ha);
        end
        req_ready = 1'b1;
        wait_next(n);
        check(n == 10, "R5", "spacing after held request", n, 10);

        // R7: stall while a request waits
        req_ready = 1'b0;
        pulse_stall();
        check(req_valid == 1'b1, "R7", "pending kept after stall", req_valid, 1);
        req_ready = 1'b1;
        @(negedge clk);
        seen = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            seen += req_valid;
        end
        check(seen == 0, "R7", "requests after deferred stall", seen, 0);

        // R9: stall while stalled ignored; R8: resume delay
        pulse_stall();
        repeat (5) @(negedge clk);
        check(req_valid == 1'b0, "R9", "valid while stalled", req_valid, 0);
        pulse_resume();
        wait_first(n);
        check(n == 10, "R8", "first request after resume", n, 10);

        // R6: stall while idle
        @(negedge clk);
        pulse_stall();
        seen = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            seen += req_valid;
        end
        check(seen == 0, "R6", "requests while stalled", seen, 0);
        pulse_resume();
        wait_first(n);
        check(n == 10, "R8", "resume delay after idle stall", n, 10);

        // R9: resume while active has no effect
        n = 0;
        do begin
            @(negedge clk);
            n++;
            resume_i = (n == 3);
        end while (!req_valid && n < 300);
        resume_i = 1'b0;
        check(n == 10, "R9", "spacing with stray resume", n, 10);

        // R10: zero seed
        @(negedge clk);
        rst = 1'b1;
        seed = 32'd0;
        repeat (2) @(negedge clk);
        load_expected(32'd0, 20);
        rst = 1'b0;
        wait_first(n);
        check(n == 10, "R2", "first request after second reset", n, 10);
        check(req_addr == '0, "R10", "first address with zero seed", req_addr, 0);
        check(req_write == 1'b0, "R10", "first request is read", req_write, 0);
        for (int k = 0; k < 4; k++) begin
            wait_next(n);
            check(n == 10, "R2", "spacing after zero seed", n, 10);
        end
        @(negedge clk);
        done = 1;
        summary();
        $finish;
    end
endmodule